// File: doc/BRIEF.md
# Strap-Sampled Frequency Select Controller

This block decides the operating configuration of a clock generator from two frequency-select strap pins. It samples the straps exactly once: at the moment an active-low power-good strobe is first seen low. Each strap is a three-level input (low, mid or high) that an analog detector outside this block reports as a 2-bit code. After the sample, the configuration is frozen until the next reset.

There are three possible configurations. In the normal configuration the block reports the CPU clock frequency in MHz. A table-select register bit chooses between the base table and the doubled table. If the second strap was at mid level when sampled, the block enters a sticky test mode. In test mode, the first strap picks, without waiting for a clock, between reference-divided outputs and high-impedance outputs. Two readback bits report the sampled strap levels.

Top module: `fsel_strap_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `locked`, `test_mode`, `test_hiz`, `rb_a` and `rb_b` are 0 and `cpu_mhz` is 0.
- R2: `pwrgd_n` passes through a two-flop synchronizer. If it is driven low before rising edge 1, `locked` is still 0 after edge 2 and becomes 1 at edge 3. The straps are captured at that same edge.
- R3: Strap codes are 2'b00 = low, 2'b01 = mid and 2'b10 or 2'b11 = high. A mid level on the first strap is taken as low. With `tbl_dbl` = 0, the sampled (first, second) pair gives `cpu_mhz` as follows: (low,low) = 100, (low,high) = 200, (high,low) = 133, (high,high) = 166.
- R4: With `tbl_dbl` = 1, the same pairs give 200, 400, 266 and 333. `tbl_dbl` is applied to the frozen sample at any time, combinationally.
- R5: Once `locked` is 1, later changes on `pwrgd_n` and on either strap do not change `cpu_mhz`, `rb_a`, `rb_b` or `test_mode`.
- R6: A mid level on the second strap at the sample sets `test_mode`, with `cpu_mhz` = 0. Later changes on the second strap do not clear it.
- R7: In test mode, `test_hiz` follows the live first strap without a clock edge: high gives 1 (high-impedance), and low or mid gives 0 (reference-divided). Outside test mode, `test_hiz` is 0.
- R8: Only a reset leaves test mode. A new sample taken with the second strap at a firm level then gives the normal configuration.
- R9: `rb_a` and `rb_b` are 1 when the first or the second strap respectively was sampled high, and 0 otherwise.
- R10: Before the first sample, `cpu_mhz` stays 0 and `test_mode` stays 0 whatever the straps do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset (power cycle) |
| pwrgd_n | input | 1 | Asynchronous active-low power-good strobe |
| strap_a | input | 2 | First strap level code |
| strap_b | input | 2 | Second strap level code |
| tbl_dbl | input | 1 | Table select: 0 = base table, 1 = doubled table |
| cpu_mhz | output | MHZ_W | CPU clock frequency in MHz, 0 when disabled |
| locked | output | 1 | Straps have been sampled |
| test_mode | output | 1 | Test clock mode active |
| test_hiz | output | 1 | Test mode output select: 1 = high-impedance, 0 = reference-divided |
| rb_a | output | 1 | Readback of sampled first strap |
| rb_b | output | 1 | Readback of sampled second strap |

## Verification
The assertions assume that the strap codes and `tbl_dbl` only change between clock edges. They also assume that once `pwrgd_n` goes low, it stays low for at least three edges, so that the synchronized low the capture relies on is real. The bench drives every input on the falling clock edge. Each strobe is held low for at least three rising edges before any check looks at the captured state. The asynchronous first-strap path in test mode is checked mid-cycle, away from any edge.

// File: rtl/fsel_strap_ctrl.sv
module fsel_strap_ctrl #(
  parameter int MHZ_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwrgd_n,
  input  logic [1:0]       strap_a,
  input  logic [1:0]       strap_b,
  input  logic             tbl_dbl,
  output logic [MHZ_W-1:0] cpu_mhz,
  output logic             locked,
  output logic             test_mode,
  output logic             test_hiz,
  output logic             rb_a,
  output logic             rb_b
);
  localparam logic [1:0] LVL_MID = 2'b01;

  logic [1:0] sync_q;
  logic       lock_q, tmode_q;
  logic [1:0] code_q;
  logic [MHZ_W-1:0] mhz_sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], pwrgd_n};

  wire take = !lock_q && !sync_q[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lock_q  <= 1'b0;
      tmode_q <= 1'b0;
      code_q  <= 2'b00;
    end else if (take) begin
      lock_q  <= 1'b1;
      tmode_q <= (strap_b == LVL_MID);
      code_q  <= {strap_a[1], strap_b[1]};
    end

  always_comb
    case ({tbl_dbl, code_q})
      3'b000:  mhz_sel = MHZ_W'(100);
      3'b001:  mhz_sel = MHZ_W'(200);
      3'b010:  mhz_sel = MHZ_W'(133);
      3'b011:  mhz_sel = MHZ_W'(166);
      3'b100:  mhz_sel = MHZ_W'(200);
      3'b101:  mhz_sel = MHZ_W'(400);
      3'b110:  mhz_sel = MHZ_W'(266);
      default: mhz_sel = MHZ_W'(333);
    endcase

  assign cpu_mhz   = (lock_q && !tmode_q) ? mhz_sel : '0;
  assign locked    = lock_q;
  assign test_mode = tmode_q;
  assign test_hiz  = tmode_q & strap_a[1];
  assign rb_a      = code_q[1];
  assign rb_b      = code_q[0];
endmodule

module fsel_strap_ctrl_chk #(
  parameter int MHZ_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwrgd_n,
  input logic [MHZ_W-1:0] cpu_mhz,
  input logic             locked,
  input logic             test_mode,
  input logic             test_hiz,
  input logic             rb_a,
  input logic             rb_b
);
  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  // R5
  rb_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> ($stable(rb_a) && $stable(rb_b)));
  // R6
  tmode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |=> test_mode);
  // R10
  unlocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (cpu_mhz == '0 && !test_mode && !test_hiz));
  // R3
  normal_freq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !test_mode) |-> (cpu_mhz != '0 && !test_hiz));
  // R2
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(pwrgd_n, 2) == 1'b0));
endmodule

bind fsel_strap_ctrl fsel_strap_ctrl_chk #(.MHZ_W(MHZ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwrgd_n(pwrgd_n), .cpu_mhz(cpu_mhz),
  .locked(locked), .test_mode(test_mode), .test_hiz(test_hiz),
  .rb_a(rb_a), .rb_b(rb_b));

// File: tb/fsel_strap_ctrl_bench.sv
module fsel_strap_ctrl_bench;
  localparam int MHZ_W = 9;
  logic clk = 1'b0, rst_n = 1'b0, pwrgd_n = 1'b1, tbl_dbl = 1'b0;
  logic [1:0] strap_a = 2'b00, strap_b = 2'b00;
  logic [MHZ_W-1:0] cpu_mhz;
  logic locked, test_mode, test_hiz, rb_a, rb_b;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  fsel_strap_ctrl #(.MHZ_W(MHZ_W)) u_fsel_strap_ctrl (.*);

  // {a[1:0], b[1:0], dbl, mhz[8:0], tm, ra, rb}
  localparam int NV = 10;
  localparam logic [16:0] VEC [NV] = '{
    {2'b00, 2'b00, 1'b0, 9'd100, 1'b0, 1'b0, 1'b0},
    {2'b00, 2'b10, 1'b0, 9'd200, 1'b0, 1'b0, 1'b1},
    {2'b10, 2'b00, 1'b0, 9'd133, 1'b0, 1'b1, 1'b0},
    {2'b11, 2'b11, 1'b0, 9'd166, 1'b0, 1'b1, 1'b1},
    {2'b00, 2'b00, 1'b1, 9'd200, 1'b0, 1'b0, 1'b0},
    {2'b00, 2'b11, 1'b1, 9'd400, 1'b0, 1'b0, 1'b1},
    {2'b10, 2'b00, 1'b1, 9'd266, 1'b0, 1'b1, 1'b0},
    {2'b10, 2'b10, 1'b1, 9'd333, 1'b0, 1'b1, 1'b1},
    {2'b01, 2'b10, 1'b0, 9'd200, 1'b0, 1'b0, 1'b1},
    {2'b00, 2'b01, 1'b0, 9'd0,   1'b1, 1'b0, 1'b0}
  };

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pwrgd_n = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic strobe();
    @(negedge clk);
    pwrgd_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1
    check("R1 locked", locked, 0);
    check("R1 cpu_mhz", cpu_mhz, 0);
    check("R1 test_mode", test_mode, 0);
    check("R1 rb", {rb_a, rb_b}, 0);

    for (int i = 0; i < NV; i++) begin
      do_reset();
      strap_a = VEC[i][16:15]; strap_b = VEC[i][14:13]; tbl_dbl = VEC[i][12];
      strobe();
      check("R3/R4/R6 cpu_mhz", cpu_mhz, int'(VEC[i][11:3]));
      check("R6 test_mode", test_mode, VEC[i][2]);
      check("R9 rb_a", rb_a, VEC[i][1]);
      check("R9 rb_b", rb_b, VEC[i][0]);
    end

    // R10: straps move before any strobe
    do_reset();
    strap_a = 2'b10; strap_b = 2'b01;
    repeat (3) @(negedge clk);
    strap_b = 2'b10;
    @(negedge clk);
    check("R10 cpu_mhz", cpu_mhz, 0);
    check("R10 test_mode", test_mode, 0);

    // R2: latency through synchronizer
    strap_a = 2'b00; strap_b = 2'b10; tbl_dbl = 1'b0;
    pwrgd_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R2 not yet locked", locked, 0);
    @(posedge clk); @(negedge clk);
    check("R2 locked at edge 3", locked, 1);
    check("R2 cpu_mhz", cpu_mhz, 200);

    // R5: later strap and strobe changes ignored
    strap_a = 2'b10; strap_b = 2'b01; pwrgd_n = 1'b1;
    repeat (3) @(negedge clk);
    pwrgd_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R5 cpu_mhz", cpu_mhz, 200);
    check("R5 test_mode", test_mode, 0);
    check("R5 rb", {rb_a, rb_b}, 1);

    // R4: table select live on frozen sample
    tbl_dbl = 1'b1; #1;
    check("R4 live dbl", cpu_mhz, 400);
    tbl_dbl = 1'b0;

    // R6/R7: test mode, async first strap
    do_reset();
    strap_a = 2'b00; strap_b = 2'b01;
    strobe();
    check("R7 hiz low", test_hiz, 0);
    @(posedge clk); #1;
    strap_a = 2'b10; #0.5;
    check("R7 hiz async high", test_hiz, 1);
    strap_a = 2'b01; #0.5;
    check("R7 hiz mid is ref", test_hiz, 0);
    strap_b = 2'b10;
    repeat (3) @(negedge clk);
    check("R6 sticky test_mode", test_mode, 1);
    check("R6 cpu_mhz", cpu_mhz, 0);

    // R8: reset leaves test mode
    do_reset();
    check("R8 test_mode after reset", test_mode, 0);
    strap_a = 2'b10; strap_b = 2'b00; tbl_dbl = 1'b0;
    strobe();
    check("R8 test_mode", test_mode, 0);
    check("R8 cpu_mhz", cpu_mhz, 133);
    check("R7 hiz outside test", test_hiz, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule